// File: doc/BRIEF.md
# Flash Program/Erase Operation Sequencer

This block carries out the long-running operations of a byte-wide flash memory on a small synthesizable array model: single-byte programming, erasure of a chosen set of blocks, and erasure of the whole array. A command decoder upstream turns bus write sequences into one-cycle start pulses. It hands over the target address, the data and, for block erase, a 16-bit block selection. The sequencer then runs the operation for a configurable number of clock cycles and drives an active-low busy output.

While an operation is running, reads return a status byte in place of array contents, and new start requests are dropped. The array is divided into 16 equal blocks, and protection is applied to pairs of blocks. Programs into protected blocks are dropped, and erases pass over protected blocks without reporting anything.

A block erase can be suspended and resumed. While it is suspended, the array can be read. An error, which can be injected for test, holds the sequencer in a status-reporting state until a read/reset command clears it. A hardware reset input aborts any operation.

Top module: `flash_op_seq`

## Requirements
- R1: After system reset `busy_n` is 1, every array byte reads 0xFF, and reads return array data.
- R2: A program request into an unprotected block holds `busy_n` low for PROG_CYCLES cycles. The addressed byte then holds the old value ANDed with the request data, so a program can only clear bits.
- R3: The block index is the top 4 address bits. Block b belongs to protection group b/2, and group g is protected when `prot_grp[g]` is 1. A program request into a protected block is dropped: `busy_n` stays 1 and the byte is unchanged.
- R4: A block erase sets every byte of each selected unprotected block to 0xFF. Blocks are erased one per ERASE_CYCLES cycles in ascending index order. Selected protected blocks are skipped without error.
- R5: A chip erase sets every byte of every unprotected block to 0xFF and leaves protected blocks unchanged.
- R6: While busy, `busy_n` is 0 and reads return the status byte. In the status byte, bit 7 is the busy flag (1 while busy) and bit 5 is the error flag; all other bits are 0, so it reads 0x80 with no error. All start requests are ignored while busy.
- R7: An erase whose effective block set is empty (for example, a chip erase with every group protected) holds `busy_n` low for SHORT_CYCLES cycles and changes no data.
- R8: A suspend request during an erase releases `busy_n` and returns array data on reads, with the erase paused. A resume request makes it busy again and finishes the remaining erase work.
- R9: `err_inject` during a program or erase moves the sequencer into an error state. It takes priority over completion in the same cycle, so the pending write is not made. Reads then return 0xA0 and `busy_n` stays 0 until `cmd_reset`. After that come RECOV_CYCLES busy cycles reading 0x80, then a return to read mode.
- R10: `hw_reset` aborts any operation. `busy_n` is 0 while the input is high and for RESET_CYCLES cycles after it falls; data not yet written stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous system reset, active low; erases the array model |
| hw_reset | input | 1 | Operation abort, active high |
| start_prog | input | 1 | Start a byte program (one-cycle pulse) |
| start_chip_erase | input | 1 | Start an erase of all unprotected blocks |
| start_blk_erase | input | 1 | Start an erase of the blocks in `blk_sel` |
| blk_sel | input | 16 | Block selection for block erase, bit b = block b |
| cmd_reset | input | 1 | Read/reset command; clears the error state |
| cmd_suspend | input | 1 | Pause a running erase |
| cmd_resume | input | 1 | Continue a paused erase |
| err_inject | input | 1 | Test input that forces an operation error |
| op_addr | input | ADDR_W | Program target address |
| op_data | input | DATA_W | Program data |
| prot_grp | input | 8 | Protection flags, one per block pair |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Array byte in read mode, otherwise the status byte |
| busy_n | output | 1 | Busy indication, active low |

## Verification
Completion of a program and an injected error can fall in the same cycle. The bench provokes this by raising `err_inject` exactly on the cycle in which the program counter reaches its last count. It judges the result by reading status 0xA0 afterwards and, once the error is cleared and recovery has run, by finding the target byte still at 0xFF. A second overlap is a suspend arriving during an erase interval while the counter is running. This is checked by reading array data during the pause and seeing the erase finish only after resume.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int NUM_BLK       = 16;
    localparam int BLK_W         = 4;
    localparam int NUM_GRP       = 8;
    localparam int STAT_BUSY_BIT = 7;
    localparam int STAT_ERR_BIT  = 5;

    typedef enum logic [2:0] {
        ST_READ,
        ST_PROG,
        ST_ERASE,
        ST_SUSP,
        ST_SHORT,
        ST_ERR,
        ST_RECOV,
        ST_HWRST
    } seq_state_t;

endpackage

// File: rtl/flash_mem_array.sv
module flash_mem_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int BLK_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_we,
    input  logic [BLK_W-1:0]  erase_blk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH   = 1 << ADDR_W;
    localparam int BLK_SH  = ADDR_W - BLK_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem[i] <= '1;
            end else if (erase_we && erase_blk == BLK_W'(i >> BLK_SH)) begin
                mem[i] <= '1;
            end else if (prog_we && prog_addr == ADDR_W'(i)) begin
                mem[i] <= mem[i] & prog_data;
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/flash_lowbit.sv
module flash_lowbit #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic [N-1:0] mask,
    output logic [W-1:0] idx,
    output logic         any
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) idx = W'(i);
        end
    end

    assign any = |mask;

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 6,
    parameter int SHORT_CYCLES = 3,
    parameter int RECOV_CYCLES = 5,
    parameter int RESET_CYCLES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hw_reset,
    input  logic               start_prog,
    input  logic               start_chip_erase,
    input  logic               start_blk_erase,
    input  logic [15:0]        blk_sel,
    input  logic               cmd_reset,
    input  logic               cmd_suspend,
    input  logic               cmd_resume,
    input  logic               err_inject,
    input  logic [ADDR_W-1:0]  op_addr,
    input  logic [DATA_W-1:0]  op_data,
    input  logic [7:0]         prot_grp,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               busy_n
);

    localparam int MAX_A  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int MAX_B  = (SHORT_CYCLES > RECOV_CYCLES) ? SHORT_CYCLES : RECOV_CYCLES;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CY = (MAX_C > RESET_CYCLES) ? MAX_C : RESET_CYCLES;
    localparam int CNT_W  = $clog2(MAX_CY + 1);

    seq_state_t         state, state_n;
    logic [CNT_W-1:0]   cnt, cnt_n, cnt_lim;
    logic [NUM_BLK-1:0] pend, pend_n, eff, blk_prot, cur_bit;
    logic [ADDR_W-1:0]  lat_addr, addr_n;
    logic [DATA_W-1:0]  lat_data, data_n;
    logic [BLK_W-1:0]   cur_idx;
    logic               cur_any, cnt_done;
    logic               prog_we, erase_we, read_mode;
    logic [DATA_W-1:0]  arr_rd, status;

    // Expand pair protection to per-block flags
    for (genvar b = 0; b < NUM_BLK; b++) begin : g_prot
        assign blk_prot[b] = prot_grp[b / 2];
    end

    flash_lowbit #(.N(NUM_BLK), .W(BLK_W)) u_lowbit (
        .mask (pend),
        .idx  (cur_idx),
        .any  (cur_any)
    );

    assign cur_bit = NUM_BLK'(1) << cur_idx;

    flash_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_we   (prog_we),
        .prog_addr (lat_addr),
        .prog_data (lat_data),
        .erase_we  (erase_we),
        .erase_blk (cur_idx),
        .rd_addr   (rd_addr),
        .rd_data   (arr_rd)
    );

    always_comb begin
        unique case (state)
            ST_PROG:  cnt_lim = CNT_W'(PROG_CYCLES);
            ST_ERASE: cnt_lim = CNT_W'(ERASE_CYCLES);
            ST_SHORT: cnt_lim = CNT_W'(SHORT_CYCLES);
            ST_RECOV: cnt_lim = CNT_W'(RECOV_CYCLES);
            ST_HWRST: cnt_lim = CNT_W'(RESET_CYCLES);
            default:  cnt_lim = CNT_W'(1);
        endcase
    end

    assign cnt_done = (cnt == cnt_lim - CNT_W'(1));

    // Next-state logic
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        pend_n  = pend;
        addr_n  = lat_addr;
        data_n  = lat_data;
        eff     = '0;
        if (hw_reset) begin
            state_n = ST_HWRST;
            cnt_n   = '0;
            pend_n  = '0;
        end else begin
            unique case (state)
                ST_READ: begin
                    if (start_prog) begin
                        if (!blk_prot[op_addr[ADDR_W-1 -: BLK_W]]) begin
                            state_n = ST_PROG;
                            cnt_n   = '0;
                            addr_n  = op_addr;
                            data_n  = op_data;
                        end
                    end else if (start_chip_erase || start_blk_erase) begin
                        eff   = start_chip_erase ? ~blk_prot : (blk_sel & ~blk_prot);
                        cnt_n = '0;
                        if (eff == '0) begin
                            state_n = ST_SHORT;
                        end else begin
                            state_n = ST_ERASE;
                            pend_n  = eff;
                        end
                    end
                end
                ST_PROG: begin
                    if (err_inject)    state_n = ST_ERR;
                    else if (cnt_done) state_n = ST_READ;
                    else               cnt_n   = cnt + CNT_W'(1);
                end
                ST_ERASE: begin
                    if (err_inject) begin
                        state_n = ST_ERR;
                        pend_n  = '0;
                    end else if (cmd_suspend) begin
                        state_n = ST_SUSP;
                    end else if (cnt_done) begin
                        cnt_n  = '0;
                        pend_n = pend & ~cur_bit;
                        if ((pend & ~cur_bit) == '0) state_n = ST_READ;
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end
                ST_SUSP: begin
                    if (cmd_resume && cur_any) state_n = ST_ERASE;
                end
                ST_SHORT, ST_RECOV, ST_HWRST: begin
                    if (cnt_done) state_n = ST_READ;
                    else          cnt_n   = cnt + CNT_W'(1);
                end
                ST_ERR: begin
                    if (cmd_reset) begin
                        state_n = ST_RECOV;
                        cnt_n   = '0;
                    end
                end
                default: state_n = ST_READ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_READ;
            cnt      <= '0;
            pend     <= '0;
            lat_addr <= '0;
            lat_data <= '1;
        end else begin
            state    <= state_n;
            cnt      <= cnt_n;
            pend     <= pend_n;
            lat_addr <= addr_n;
            lat_data <= data_n;
        end
    end

    // Outputs
    always_comb begin
        read_mode = (state == ST_READ) || (state == ST_SUSP);
        busy_n    = read_mode;
        status    = '0;
        status[STAT_BUSY_BIT] = 1'b1;
        status[STAT_ERR_BIT]  = (state == ST_ERR);
        rd_data   = read_mode ? arr_rd : status;
        prog_we   = (state == ST_PROG) && cnt_done && !hw_reset && !err_inject;
        erase_we  = (state == ST_ERASE) && cnt_done && !hw_reset && !err_inject
                    && !cmd_suspend;
    end

endmodule

// File: rtl/flash_op_seq_chk.sv
module flash_op_seq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_reset,
    input logic              start_prog,
    input logic              start_chip_erase,
    input logic              start_blk_erase,
    input logic              cmd_reset,
    input logic              cmd_resume,
    input logic [DATA_W-1:0] rd_data,
    input logic              busy_n
);

    assert_hwrst_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hw_reset |=> !busy_n);

    assert_status_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |-> rd_data[7]);

    assert_busy_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |-> $past(start_prog || start_chip_erase || start_blk_erase
                                || hw_reset || cmd_resume));

    assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && rd_data[5] && !cmd_reset && !hw_reset) |=> (!busy_n && rd_data[5]));

endmodule

bind flash_op_seq flash_op_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_flash_op_seq.sv
module tb_flash_op_seq;

    localparam int CLK_PERIOD = 10;
    localparam int P  = 4;
    localparam int E  = 6;
    localparam int S  = 3;
    localparam int RC = 5;
    localparam int RS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_reset = 1'b0;
    logic        start_prog = 1'b0, start_chip_erase = 1'b0, start_blk_erase = 1'b0;
    logic [15:0] blk_sel = '0;
    logic        cmd_reset = 1'b0, cmd_suspend = 1'b0, cmd_resume = 1'b0, err_inject = 1'b0;
    logic [7:0]  op_addr = '0, op_data = '0, prot_grp = '0, rd_addr = '0;
    logic [7:0]  rd_data;
    logic        busy_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_op_seq #(
        .ADDR_W(8), .DATA_W(8), .PROG_CYCLES(P), .ERASE_CYCLES(E),
        .SHORT_CYCLES(S), .RECOV_CYCLES(RC), .RESET_CYCLES(RS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset), .start_prog(start_prog),
        .start_chip_erase(start_chip_erase), .start_blk_erase(start_blk_erase),
        .blk_sel(blk_sel), .cmd_reset(cmd_reset), .cmd_suspend(cmd_suspend),
        .cmd_resume(cmd_resume), .err_inject(err_inject), .op_addr(op_addr),
        .op_data(op_data), .prot_grp(prot_grp), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy_n(busy_n)
    );

    // {addr, data, expected byte afterwards}
    localparam logic [23:0] PROG_VEC [7] = '{
        {8'h10, 8'hF0, 8'hF0},
        {8'h10, 8'h3C, 8'h30},
        {8'h23, 8'h5A, 8'h5A},
        {8'h23, 8'hFF, 8'h5A},
        {8'h7F, 8'h00, 8'h00},
        {8'h45, 8'h00, 8'h00},
        {8'h50, 8'h11, 8'h11}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic check_busy(input string tag, input logic exp);
        check(tag, {7'd0, busy_n}, {7'd0, exp});
    endtask

    task automatic do_prog(input logic [7:0] a, input logic [7:0] d);
        op_addr = a;
        op_data = d;
        start_prog = 1'b1;
        @(negedge clk);
        start_prog = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check_busy("R1 busy_n after reset", 1'b1);
        check_rd("R1 erased byte low", 8'h00, 8'hFF);
        check_rd("R1 erased byte high", 8'hFF, 8'hFF);

        // R2 / R6 table-driven programs
        foreach (PROG_VEC[i]) begin
            do_prog(PROG_VEC[i][23:16], PROG_VEC[i][15:8]);
            check_busy("R6 busy during program", 1'b0);
            check_rd("R6 status during program", PROG_VEC[i][23:16], 8'h80);
            tick(P);
            check_busy("R2 ready after program", 1'b1);
            check_rd("R2 programmed value", PROG_VEC[i][23:16], PROG_VEC[i][7:0]);
        end

        // R3 program into protected pair (blocks 2,3)
        prot_grp = 8'h02;
        do_prog(8'h23, 8'h00);
        check_busy("R3 protected program not busy", 1'b1);
        tick(P);
        check_rd("R3 protected byte unchanged", 8'h23, 8'h5A);

        // R4 block erase of blocks 1,2,7 with block 2 protected
        blk_sel = 16'h0086;
        start_blk_erase = 1'b1;
        @(negedge clk);
        start_blk_erase = 1'b0;
        check_busy("R4 busy at erase start", 1'b0);
        tick(E);
        check_busy("R4 still busy after first block", 1'b0);
        rd_addr = 8'h10; #1;
        check("R4 first block still busy status", rd_data, 8'h80);
        tick(E);
        check_busy("R4 ready after two blocks", 1'b1);
        check_rd("R4 block1 erased", 8'h10, 8'hFF);
        check_rd("R4 block7 erased", 8'h7F, 8'hFF);
        check_rd("R4 protected block2 kept", 8'h23, 8'h5A);

        // R5 chip erase with R6 ignored program in between (14 unprotected blocks)
        start_chip_erase = 1'b1;
        @(negedge clk);
        start_chip_erase = 1'b0;
        tick(E + 1);
        do_prog(8'h05, 8'h00);
        check_rd("R6 status during chip erase", 8'h05, 8'h80);
        tick(13 * E - 2);
        check_busy("R5 ready after chip erase", 1'b1);
        check_rd("R6 program during erase ignored", 8'h05, 8'hFF);
        check_rd("R5 block4 erased", 8'h45, 8'hFF);
        check_rd("R5 block5 erased", 8'h50, 8'hFF);
        check_rd("R5 protected block kept", 8'h23, 8'h5A);

        // R7 chip erase with everything protected
        prot_grp = 8'hFF;
        start_chip_erase = 1'b1;
        @(negedge clk);
        start_chip_erase = 1'b0;
        check_busy("R7 busy on empty erase", 1'b0);
        tick(S - 1);
        check_busy("R7 busy on last short cycle", 1'b0);
        tick(1);
        check_busy("R7 ready after short interval", 1'b1);
        check_rd("R7 data unchanged", 8'h23, 8'h5A);
        prot_grp = 8'h00;

        // R8 suspend / resume of block 4 erase
        do_prog(8'h45, 8'h00);
        tick(P);
        blk_sel = 16'h0010;
        start_blk_erase = 1'b1;
        @(negedge clk);
        start_blk_erase = 1'b0;
        tick(1);
        cmd_suspend = 1'b1;
        @(negedge clk);
        cmd_suspend = 1'b0;
        check_busy("R8 released on suspend", 1'b1);
        check_rd("R8 array readable while suspended", 8'h45, 8'h00);
        tick(10);
        check_busy("R8 stays suspended", 1'b1);
        check_rd("R8 no erase progress while suspended", 8'h45, 8'h00);
        cmd_resume = 1'b1;
        @(negedge clk);
        cmd_resume = 1'b0;
        check_busy("R8 busy after resume", 1'b0);
        tick(E + 1);
        check_busy("R8 ready after resumed erase", 1'b1);
        check_rd("R8 block erased after resume", 8'h45, 8'hFF);

        // R9 error on the same cycle as program completion
        do_prog(8'h60, 8'h00);
        tick(P - 1);
        err_inject = 1'b1;
        @(negedge clk);
        err_inject = 1'b0;
        check_busy("R9 busy in error", 1'b0);
        check_rd("R9 error status", 8'h60, 8'hA0);
        tick(20);
        check_rd("R9 error status persists", 8'h60, 8'hA0);
        cmd_reset = 1'b1;
        @(negedge clk);
        cmd_reset = 1'b0;
        check_rd("R9 recovery status", 8'h60, 8'h80);
        tick(RC);
        check_busy("R9 ready after recovery", 1'b1);
        check_rd("R9 write dropped on error", 8'h60, 8'hFF);

        // R10 hardware reset during erase
        do_prog(8'h60, 8'h00);
        tick(P);
        blk_sel = 16'h0040;
        start_blk_erase = 1'b1;
        @(negedge clk);
        start_blk_erase = 1'b0;
        tick(2);
        hw_reset = 1'b1;
        @(negedge clk);
        hw_reset = 1'b0;
        check_busy("R10 busy after hw reset", 1'b0);
        tick(RS);
        check_busy("R10 ready after reset delay", 1'b1);
        check_rd("R10 aborted erase left data", 8'h60, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule